// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial bus (SCL clock, SDA data) in front of a 256-word by 8-bit memory held in registers inside the block. A fast system clock oversamples both bus lines through a synchronizer. Start and stop conditions are recognised on the synchronized lines. The block then takes an address byte and compares its upper seven bits with a fixed type code followed by three strap pins. It serves single-byte writes, multi-byte writes, and random, current-address and sequential reads. SDA is only ever pulled low, through an open-drain enable output. The surrounding pad logic drives SDA low while `sda_oe` is high and otherwise leaves it floating.

Write bytes are not stored in the memory as they arrive. They go into a small buffer of `PAGE` slots, and each slot holds a word address and a data byte. The buffer is copied into the memory in one system clock cycle, and only when a stop condition ends the transfer while the write-protect input is low. A repeated start or a protected stop empties the buffer. A single 8-bit address pointer is shared by reads and writes. It persists between transfers, which lets a current-address read continue from where the last access ended.

The controller has these states. `S_IDLE` waits for a start. `S_ADDR` shifts in the address byte. `S_ADDR_ACK` acknowledges a match. `S_WADDR` and `S_WADDR_ACK` take the word address. `S_WDATA` and `S_WDATA_ACK` buffer write bytes. `S_RDATA` shifts a read byte out. `S_RACK` samples the master's acknowledge.

The transitions are as follows:
- A start moves any state to `S_ADDR`, and a stop moves any state to `S_IDLE`.
- From `S_ADDR`, the eighth bit leads to `S_ADDR_ACK` on a match and to `S_IDLE` otherwise.
- From `S_ADDR_ACK`, the end of the acknowledge clock leads to `S_RDATA` for a read or to `S_WADDR` for a write.
- `S_WADDR` leads to `S_WADDR_ACK`, and `S_WADDR_ACK` leads to `S_WDATA`.
- `S_WDATA` and `S_WDATA_ACK` alternate.
- `S_RDATA` leads to `S_RACK` after eight bits.
- From `S_RACK`, an acknowledge from the master leads back to `S_RDATA`, and a not-acknowledge leads to `S_IDLE`.

Top module: `twowire_eeprom_slave`

## Requirements
- R1: After reset `sda_oe` is low and every memory word reads back as 0x00.
- R2: Before the first start condition (SDA falling while SCL is high), clocked bits get no response: SDA is never pulled low.
- R3: The address byte is sent MSB first. Its bits 7..4 must be 1010 and its bits 3..1 must equal `strap[2]`, `strap[1]`, `strap[0]`. On a match the block pulls SDA low during the ninth clock. On a mismatch it does not, and it ignores all further bits until the next start.
- R4: When bit 0 of the address byte is 0, the next byte loads the word address pointer. Each following byte is buffered at the pointer, then the pointer advances. Every such byte is acknowledged.
- R5: Buffered write data reaches the memory only when a stop condition (SDA rising while SCL is high) ends the transfer. A repeated start discards the buffered bytes, and the memory stays unchanged.
- R6: If `wp_in` is high when the stop arrives, none of the buffered bytes are written.
- R7: When bit 0 of the address byte is 1, data is sent MSB first from the word at the pointer. `sda_oe` changes only while SCL is low.
- R8: The pointer advances after each byte read or buffered and wraps from 255 to 0. A read address byte with no word address phase reads from the current pointer.
- R9: A not-acknowledge (SDA high on the ninth clock) after a read byte ends the read, and SDA stays released until the next start.
- R10: At most `PAGE` (8) bytes are held per write. Byte k of a transfer goes to slot k mod 8, so the ninth byte replaces the first byte's address and data, and the first address keeps its old content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND result) |
| strap | input | 3 | Device select pins, compared with address bits 3..1 |
| wp_in | input | 1 | Write protect, high blocks commits |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
A wrong state or bit counter shows up within one byte time. It appears as a missing or misplaced acknowledge on the ninth clock, or as a read byte shifted by a bit position. A pointer error stays hidden until the next read. For that reason the whole memory is filled and then read back in a single sequential pass that runs past the wrap point. Commit errors affect only stored content, so each discarded or protected write is followed at once by a read of the affected word.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [3:0] TYPE_CODE = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_WADDR,
        S_WADDR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RACK
    } eep_state_e;

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                scl_q[g] <= 1'b1;
                sda_q[g] <= 1'b1;
            end else if (g == 0) begin
                scl_q[g] <= scl_in;
                sda_q[g] <= sda_in;
            end else begin
                scl_q[g] <= scl_q[(g == 0) ? 0 : g-1];
                sda_q[g] <= sda_q[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign scl_lvl = scl_q[STAGES-1];
    assign sda_lvl = sda_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_lvl;
            sda_d <= sda_lvl;
        end
    end

    assign scl_rise = scl_lvl & ~scl_d;
    assign scl_fall = ~scl_lvl & scl_d;
    assign start_ev = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int AW   = 8,
    parameter int DW   = 8,
    parameter int PAGE = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_we,
    input  logic          buf_clr,
    input  logic          commit,
    input  logic [AW-1:0] buf_addr,
    input  logic [DW-1:0] buf_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;
    localparam int SW    = (PAGE > 1) ? $clog2(PAGE) : 1;

    logic [DW-1:0]   mem    [DEPTH];
    logic [AW-1:0]   slot_a [PAGE];
    logic [DW-1:0]   slot_d [PAGE];
    logic [PAGE-1:0] slot_v;
    logic [SW-1:0]   wr_slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_v  <= '0;
            wr_slot <= '0;
        end else if (buf_clr) begin
            slot_v  <= '0;
            wr_slot <= '0;
        end else if (buf_we) begin
            slot_v[wr_slot] <= 1'b1;
            wr_slot         <= (wr_slot == SW'(PAGE-1)) ? '0 : wr_slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we) begin
            slot_a[wr_slot] <= buf_addr;
            slot_d[wr_slot] <= buf_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit) begin
            for (int i = 0; i < PAGE; i++) begin
                if (slot_v[i]) mem[slot_a[i]] <= slot_d[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];

    AST_MEM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> (!$stable(rd_addr) || $stable(rd_data))); // R5

endmodule

// File: rtl/twowire_eeprom_slave.sv
module twowire_eeprom_slave
    import eep_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 8,
    parameter int PAGE        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] strap,
    input  logic       wp_in,
    output logic       sda_oe
);

    localparam int BW = $clog2(DW);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

    eep_state_e    state;
    logic [BW-1:0] cnt;
    logic [DW-1:0] shreg;
    logic [DW-1:0] byte_in;
    logic [AW-1:0] ptr;
    logic          rw;
    logic          seen;
    logic          id_match;
    logic          last_bit;
    logic          buf_we, buf_clr, mem_commit;
    logic [DW-1:0] rd_data;

    eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    assign byte_in  = {shreg[DW-2:0], sda_lvl};
    assign id_match = (byte_in[7:1] == {TYPE_CODE, strap});
    assign last_bit = scl_rise && (cnt == BW'(DW-1));

    assign buf_we     = (state == S_WDATA) && last_bit && !start_ev && !stop_ev;
    assign buf_clr    = start_ev || stop_ev;
    assign mem_commit = stop_ev && !wp_in;

    eep_store #(.AW(AW), .DW(DW), .PAGE(PAGE)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .buf_we   (buf_we),
        .buf_clr  (buf_clr),
        .commit   (mem_commit),
        .buf_addr (ptr),
        .buf_data (byte_in),
        .rd_addr  (ptr),
        .rd_data  (rd_data)
    );

    // state register, bit counter, shifter and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
            shreg <= '0;
            ptr   <= '0;
            rw    <= 1'b0;
            seen  <= 1'b0;
        end else if (start_ev) begin
            state <= S_ADDR;
            cnt   <= '0;
            seen  <= 1'b0;
        end else if (stop_ev) begin
            state <= S_IDLE;
            cnt   <= '0;
            seen  <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                end
                S_ADDR: if (scl_rise) begin
                    shreg <= byte_in;
                    cnt   <= cnt + 1'b1;
                    if (last_bit) begin
                        if (id_match) begin
                            rw    <= sda_lvl;
                            state <= S_ADDR_ACK;
                            seen  <= 1'b0;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (scl_rise) seen <= 1'b1;
                    if (scl_fall && seen) begin
                        state <= rw ? S_RDATA : S_WADDR;
                        cnt   <= '0;
                    end
                end
                S_WADDR: if (scl_rise) begin
                    shreg <= byte_in;
                    cnt   <= cnt + 1'b1;
                    if (last_bit) begin
                        ptr   <= byte_in[AW-1:0];
                        state <= S_WADDR_ACK;
                        seen  <= 1'b0;
                    end
                end
                S_WADDR_ACK, S_WDATA_ACK: begin
                    if (scl_rise) seen <= 1'b1;
                    if (scl_fall && seen) begin
                        state <= S_WDATA;
                        cnt   <= '0;
                    end
                end
                S_WDATA: if (scl_rise) begin
                    shreg <= byte_in;
                    cnt   <= cnt + 1'b1;
                    if (last_bit) begin
                        ptr   <= ptr + 1'b1;
                        state <= S_WDATA_ACK;
                        seen  <= 1'b0;
                    end
                end
                S_RDATA: if (scl_rise) begin
                    cnt <= cnt + 1'b1;
                    if (last_bit) begin
                        ptr   <= ptr + 1'b1;
                        state <= S_RACK;
                        seen  <= 1'b0;
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        if (sda_lvl) state <= S_IDLE;
                        else         seen  <= 1'b1;
                    end
                    if (scl_fall && seen) begin
                        state <= S_RDATA;
                        cnt   <= '0;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // open-drain output: updated only on SCL falling edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe <= 1'b0;
        end else if (start_ev || stop_ev) begin
            sda_oe <= 1'b0;
        end else if (scl_fall) begin
            unique case (state)
                S_ADDR_ACK:               sda_oe <= seen ? (rw && !rd_data[DW-1]) : 1'b1;
                S_WADDR_ACK, S_WDATA_ACK: sda_oe <= !seen;
                S_RDATA:                  sda_oe <= !rd_data[BW'(DW-1) - cnt];
                S_RACK:                   sda_oe <= seen && !rd_data[DW-1];
                default:                  sda_oe <= 1'b0;
            endcase
        end
    end

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sda_oe); // R2

    AST_MISMATCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR && last_bit && !id_match && !start_ev && !stop_ev)
        |=> (state == S_IDLE)); // R3

    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RACK && scl_rise && sda_lvl && !start_ev && !stop_ev)
        |=> (state == S_IDLE && !sda_oe)); // R9

endmodule

// File: tb/tb_twowire_eeprom_slave.sv
module tb_twowire_eeprom_slave;

    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       m_scl, m_sda;
    logic [2:0] strap;
    logic       wp;
    logic       sda_oe;
    wire        sda_bus = m_sda & ~sda_oe;

    int total  = 0;
    int failed = 0;
    logic [7:0] model [256];
    logic [7:0] wbuf  [16];

    always #5 clk = ~clk;

    twowire_eeprom_slave dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (m_scl),
        .sda_in (sda_bus),
        .strap  (strap),
        .wp_in  (wp),
        .sda_oe (sda_oe)
    );

    task automatic qwait(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qwait(1);
        m_scl = 1'b1; qwait(1);
        m_sda = 1'b0; qwait(1);
        m_scl = 1'b0; qwait(1);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qwait(1);
        m_scl = 1'b1; qwait(1);
        m_sda = 1'b1; qwait(2);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    qwait(1);
        m_scl = 1'b1; qwait(2);
        m_scl = 1'b0; qwait(1);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; qwait(1);
        m_scl = 1'b1; qwait(1);
        b = sda_bus;  qwait(1);
        m_scl = 1'b0; qwait(1);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~give_ack);
    endtask

    // write transfer from wbuf; R4 ack checks
    task automatic write_tx(input logic [7:0] wa, input int n, input logic do_stop);
        logic ack;
        bus_start();
        send_byte({4'hA, strap, 1'b0}, ack); chk("R4 dev ack", ack, 1);
        send_byte(wa, ack);                  chk("R4 word addr ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);         chk("R4 data ack", ack, 1);
        end
        if (do_stop) bus_stop();
    endtask

    // expected memory after a committed write (R10 slot rule)
    task automatic model_apply(input logic [7:0] wa, input int n);
        for (int i = 0; i < n; i++)
            if (i + 8 >= n) model[8'(wa + i)] = wbuf[i];
    endtask

    task automatic read_rand(input logic [7:0] wa, input int n, input string req);
        logic ack;
        logic [7:0] v;
        bus_start();
        send_byte({4'hA, strap, 1'b0}, ack); chk("R4 dev ack", ack, 1);
        send_byte(wa, ack);                  chk("R4 word addr ack", ack, 1);
        bus_start();
        send_byte({4'hA, strap, 1'b1}, ack); chk("R7 read dev ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, v);
            chk(req, v, model[8'(wa + i)]);
        end
    endtask

    initial begin
        fork
            begin : main
                logic ack;
                logic b;
                logic [7:0] v;
                rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; strap = 3'd5; wp = 1'b0;
                for (int i = 0; i < 256; i++) model[i] = 8'h00;
                repeat (5) @(negedge clk);
                rst_n = 1'b1;
                repeat (3) @(negedge clk);
                chk("R1 oe after reset", sda_oe, 0);

                // R2: bits without a start
                m_scl = 1'b0; qwait(1);
                send_byte({4'hA, strap, 1'b0}, ack);
                chk("R2 no ack before start", ack, 0);

                // R1: memory cleared
                read_rand(8'h10, 2, "R1 reset contents");
                bus_stop();

                // R3: sweep every address byte with strap=5
                for (int a = 0; a < 128; a++) begin
                    bus_start();
                    send_byte(8'(a << 1), ack);
                    chk("R3 addr sweep", ack, (a == ((10 << 3) | 5)) ? 1 : 0);
                    bus_stop();
                end
                // R3: every strap setting, own and neighbour address
                for (int s = 0; s < 8; s++) begin
                    strap = 3'(s); qwait(1);
                    bus_start();
                    send_byte({4'hA, 3'(s), 1'b0}, ack); chk("R3 strap match", ack, 1);
                    bus_stop();
                    bus_start();
                    send_byte({4'hA, 3'(s ^ 2), 1'b0}, ack); chk("R3 strap mismatch", ack, 0);
                    bus_stop();
                end
                strap = 3'd5; qwait(1);
                // R3: after mismatch, later bytes ignored
                bus_start();
                send_byte({4'hB, strap, 1'b0}, ack); chk("R3 wrong type", ack, 0);
                send_byte({4'hA, strap, 1'b0}, ack); chk("R3 ignored after mismatch", ack, 0);
                bus_stop();

                // R4: fill memory in 8-byte pages, data = a*7+3
                for (int p = 0; p < 32; p++) begin
                    for (int i = 0; i < 8; i++) wbuf[i] = 8'((p * 8 + i) * 7 + 3);
                    write_tx(8'(p * 8), 8, 1'b1);
                    model_apply(8'(p * 8), 8);
                end

                // R7/R8: sequential read across wrap
                read_rand(8'h00, 257, "R8 sequential read with wrap");
                recv_bit(b); chk("R9 released after nack", b, 1);
                recv_bit(b); chk("R9 still released", b, 1);
                bus_stop();
                // R8: current address read, pointer is 257 mod 256 = 1
                bus_start();
                send_byte({4'hA, strap, 1'b1}, ack); chk("R8 current read ack", ack, 1);
                recv_byte(1'b0, v); chk("R8 current address read", v, model[1]);
                bus_stop();

                // R5: repeated start discards write
                wbuf[0] = 8'hAA;
                write_tx(8'h20, 1, 1'b0);
                read_rand(8'h20, 1, "R5 discarded by repeated start");
                bus_stop();
                read_rand(8'h20, 1, "R5 still old after stop");
                bus_stop();

                // R6: write protect
                wp = 1'b1;
                wbuf[0] = 8'h55;
                write_tx(8'h30, 1, 1'b1);
                wp = 1'b0;
                read_rand(8'h30, 1, "R6 protected write blocked");
                bus_stop();
                write_tx(8'h30, 1, 1'b1);
                model_apply(8'h30, 1);
                read_rand(8'h30, 1, "R6 unprotected write lands");
                bus_stop();
                chk("R6 value 0x55 stored", model[8'h30], 8'h55);

                // R10: nine bytes into an 8-slot buffer
                for (int i = 0; i < 9; i++) wbuf[i] = 8'(8'hC0 + i);
                write_tx(8'h40, 9, 1'b1);
                model_apply(8'h40, 9);
                read_rand(8'h40, 9, "R10 buffer overflow");
                bus_stop();

                // R8: write pointer wraps 255 -> 0
                wbuf[0] = 8'h11; wbuf[1] = 8'h22;
                write_tx(8'hFF, 2, 1'b1);
                model_apply(8'hFF, 2);
                read_rand(8'hFF, 2, "R8 write wrap");
                bus_stop();
            end
            begin : watchdog
                repeat (195000) @(posedge clk);
                total++; failed++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule